// File: doc/BRIEF.md
# Serial Audio DSP Port

This block is the master side of a serial link that carries 16-bit stereo samples between an audio core and an external DSP. It makes the bit clock and the frame sync itself. On its output pin it sends a left and a right playback word each frame. On its input pin it captures a left and a right word from the DSP and passes that pair on toward the DACs. A mono setting sends silence on the right output slot and copies the received left word to both DAC channels.

Software controls the port through a small register. It holds a port-enable bit, a two-bit format code, a mono bit and a mode-change-enable bit. The port-enable bit and the format code can only be altered while mode-change-enable is already set. Only format code 0 is built: a 64-slot frame in which the sync pulse fills the single slot just before the first data bit. The other three codes are reserved and keep the link idle.

Samples enter through a valid/ready handshake. Captured pairs leave as a one-cycle valid pulse per frame. While the port is disabled, the pad output enable is low, so the pads float, and the pin values are held low.

Top module: `sdp_serial_port`

## Requirements
- R1: After reset the mode-change-enable, port-enable, format and mono bits are all 0. `pins_oe_o`, `sclk_o`, `fsync_o`, `sdout_o` and `rx_valid_o` are 0, and `tx_ready_o` is 1.
- R2: A write with `cfg_we_i` always loads the mode-change-enable and mono bits. It loads the port-enable bit and the format code only if mode-change-enable was 1 before that write. Otherwise those two fields keep their values.
- R3: `pins_oe_o` equals the port-enable bit. While it is 0, `sclk_o`, `fsync_o` and `sdout_o` are held at 0 from the following cycle on.
- R4: Format code 0 runs the frame described below. Codes 1, 2 and 3 are reserved: the bit clock stays low, `fsync_o` and `sdout_o` stay 0, and `pins_oe_o` still follows the port-enable bit.
- R5: The bit clock has a period of `CLK_DIV` system cycles. It is low for the first `CLK_DIV/2` cycles of each bit period and high for the rest.
- R6: A frame has 64 bit periods, numbered 0 to 63. `fsync_o` is high for exactly one bit period, period 63, which directly precedes period 0. The first bit period after the port starts is a sync period.
- R7: `sdout_o` carries the left word in periods 0 to 15 and the right word in periods 16 to 31, MSB first, and 0 in periods 32 to 63. `sdout_o` and `fsync_o` change only on the falling edge of the bit clock.
- R8: `tx_ready_o` is high while the one-pair holding register is empty. A pair is accepted in a cycle in which `tx_valid_i` and `tx_ready_o` are both high. The held pair moves to the output shifter when the sync period begins. If no pair is held at that point, zeros are sent for that frame.
- R9: `sdin_i` is sampled on each rising edge of the bit clock in periods 0 to 31, MSB first, left word first. Its value in periods 32 to 63 is ignored.
- R10: `rx_valid_o` pulses for one cycle when the sync period begins, carrying the pair from the frame just ended. It does not pulse until one complete frame has been received since the port started.
- R11: With the mono bit set, the right word sent is 0, and `rx_right_o` equals `rx_left_o`. The mono bit is read when a pair is loaded for sending and when a received pair is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mce_i | input | 1 | Mode-change-enable value to write |
| cfg_en_i | input | 1 | Port-enable value to write (gated) |
| cfg_fmt_i | input | 2 | Format code to write (gated) |
| cfg_mono_i | input | 1 | Mono bit value to write |
| tx_valid_i | input | 1 | Playback pair valid |
| tx_ready_o | output | 1 | Holding register empty |
| tx_left_i | input | WORD_W | Playback left word |
| tx_right_i | input | WORD_W | Playback right word |
| rx_valid_o | output | 1 | Captured pair valid, one cycle per frame |
| rx_left_o | output | WORD_W | Captured left word for the left DAC |
| rx_right_o | output | WORD_W | Captured right word for the right DAC |
| sdin_i | input | 1 | Serial data from the DSP |
| sclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync |
| sdout_o | output | 1 | Serial data to the DSP |
| pins_oe_o | output | 1 | Output enable for the serial pads |

## Verification
The checker assumes that `CLK_DIV` is even and at least 2, and that the mono bit changes only while the port is stopped. Without the second condition, a pair loaded under one mono setting could leave under another. The stimulus changes mono only in a write that also disables the port. The bench acts as the DSP: it moves `sdin_i` only after it sees a falling edge of the bit clock, so the bit is stable at the rising edge that samples it. Playback pairs are offered through the handshake and never forced into the holding register, and the feed is paused for whole frames to exercise the underrun path.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int unsigned SLOT_CNT = 64;
  localparam int unsigned SLOT_W   = $clog2(SLOT_CNT);
  localparam logic [SLOT_W-1:0] SYNC_SLOT = SLOT_W'(SLOT_CNT - 1);

  typedef enum logic [1:0] {
    FMT_ENH64 = 2'd0,
    FMT_RSV1  = 2'd1,
    FMT_RSV2  = 2'd2,
    FMT_RSV3  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic mce;
    logic en;
    fmt_e fmt;
    logic mono;
  } cfg_t;
endpackage

// File: rtl/sdp_cfg_regs.sv
module sdp_cfg_regs
  import sdp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       mce_i,
  input  logic       en_i,
  input  logic [1:0] fmt_i,
  input  logic       mono_i,
  output cfg_t       cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q.mce  <= mce_i;
      cfg_q.mono <= mono_i;
      // enable and format only move while the gate was already open
      if (cfg_q.mce) begin
        cfg_q.en  <= en_i;
        cfg_q.fmt <= fmt_e'(fmt_i);
      end
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/sdp_bit_clk.sv
module sdp_bit_clk
  import sdp_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  output logic              sclk_o,
  output logic              fsync_o,
  output logic              fall_o,
  output logic              rise_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SLOT_W-1:0] nxt_slot_o
);
  localparam int unsigned PH_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(CLK_DIV / 2 - 1);
  // idle slot sits one before sync so the first period after start is sync
  localparam logic [SLOT_W-1:0] IDLE_SLOT = SLOT_W'(SLOT_CNT - 2);

  logic [PH_W-1:0]   ph_q;
  logic [SLOT_W-1:0] slot_q;
  logic              sclk_q, fsync_q;

  assign fall_o     = run_i && (ph_q == PH_LAST);
  assign rise_o     = run_i && (ph_q == PH_RISE);
  assign nxt_slot_o = slot_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_LAST;
      slot_q  <= IDLE_SLOT;
      sclk_q  <= 1'b0;
      fsync_q <= 1'b0;
    end else if (!run_i) begin
      ph_q    <= PH_LAST;
      slot_q  <= IDLE_SLOT;
      sclk_q  <= 1'b0;
      fsync_q <= 1'b0;
    end else if (fall_o) begin
      ph_q    <= '0;
      slot_q  <= nxt_slot_o;
      sclk_q  <= 1'b0;
      fsync_q <= (nxt_slot_o == SYNC_SLOT);
    end else begin
      ph_q <= ph_q + 1'b1;
      if (rise_o) sclk_q <= 1'b1;
    end
  end

  assign sclk_o  = sclk_q;
  assign fsync_o = fsync_q;
  assign slot_o  = slot_q;
endmodule

// File: rtl/sdp_tx.sv
module sdp_tx
  import sdp_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              fall_i,
  input  logic [SLOT_W-1:0] nxt_slot_i,
  input  logic              mono_i,
  input  logic              tx_valid_i,
  input  logic [WORD_W-1:0] tx_left_i,
  input  logic [WORD_W-1:0] tx_right_i,
  output logic              tx_ready_o,
  output logic              sdout_o
);
  localparam int unsigned PAIR_W = 2 * WORD_W;
  localparam logic [SLOT_W-1:0] DATA_END = SLOT_W'(PAIR_W);

  logic [PAIR_W-1:0] hold_q, shift_q;
  logic              full_q, sdout_q;
  logic              accept, load;

  assign tx_ready_o = !full_q;
  assign accept     = tx_valid_i && !full_q;
  assign load       = fall_i && (nxt_slot_i == SYNC_SLOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (accept) hold_q <= {tx_left_i, tx_right_i};
      full_q <= accept || (full_q && !load);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      sdout_q <= 1'b0;
    end else if (!run_i) begin
      sdout_q <= 1'b0;
    end else if (load) begin
      // underrun sends a silent frame
      shift_q <= full_q ? {hold_q[PAIR_W-1:WORD_W],
                           mono_i ? {WORD_W{1'b0}} : hold_q[WORD_W-1:0]}
                        : '0;
      sdout_q <= 1'b0;
    end else if (fall_i) begin
      if (nxt_slot_i < DATA_END) begin
        sdout_q <= shift_q[PAIR_W-1];
        shift_q <= shift_q << 1;
      end else begin
        sdout_q <= 1'b0;
      end
    end
  end

  assign sdout_o = sdout_q;
endmodule

// File: rtl/sdp_rx.sv
module sdp_rx
  import sdp_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] nxt_slot_i,
  input  logic              mono_i,
  input  logic              sdin_i,
  output logic              rx_valid_o,
  output logic [WORD_W-1:0] rx_left_o,
  output logic [WORD_W-1:0] rx_right_o
);
  localparam int unsigned PAIR_W = 2 * WORD_W;
  localparam logic [SLOT_W-1:0] DATA_END = SLOT_W'(PAIR_W);

  logic [PAIR_W-1:0] shift_q;
  logic [WORD_W-1:0] left_q, right_q;
  logic              started_q, valid_q, done;

  assign done = started_q && fall_i && (nxt_slot_i == SYNC_SLOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      shift_q   <= '0;
    end else begin
      if (!run_i) started_q <= 1'b0;
      else if (fall_i && nxt_slot_i == '0) started_q <= 1'b1;
      if (rise_i && slot_i < DATA_END) shift_q <= {shift_q[PAIR_W-2:0], sdin_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      valid_q <= done;
      if (done) begin
        left_q  <= shift_q[PAIR_W-1:WORD_W];
        right_q <= mono_i ? shift_q[PAIR_W-1:WORD_W] : shift_q[WORD_W-1:0];
      end
    end
  end

  assign rx_valid_o = valid_q;
  assign rx_left_o  = left_q;
  assign rx_right_o = right_q;
endmodule

// File: rtl/sdp_serial_port.sv
module sdp_serial_port
  import sdp_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned WORD_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_mce_i,
  input  logic              cfg_en_i,
  input  logic [1:0]        cfg_fmt_i,
  input  logic              cfg_mono_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [WORD_W-1:0] tx_left_i,
  input  logic [WORD_W-1:0] tx_right_i,
  output logic              rx_valid_o,
  output logic [WORD_W-1:0] rx_left_o,
  output logic [WORD_W-1:0] rx_right_o,
  input  logic              sdin_i,
  output logic              sclk_o,
  output logic              fsync_o,
  output logic              sdout_o,
  output logic              pins_oe_o
);
  cfg_t              cfg_q;
  logic              run, fall, rise;
  logic [SLOT_W-1:0] slot, nxt_slot;

  sdp_cfg_regs u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .mce_i  (cfg_mce_i),
    .en_i   (cfg_en_i),
    .fmt_i  (cfg_fmt_i),
    .mono_i (cfg_mono_i),
    .cfg_o  (cfg_q)
  );

  // reserved codes leave the link idle
  assign run       = cfg_q.en && (cfg_q.fmt == FMT_ENH64);
  assign pins_oe_o = cfg_q.en;

  sdp_bit_clk #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .sclk_o     (sclk_o),
    .fsync_o    (fsync_o),
    .fall_o     (fall),
    .rise_o     (rise),
    .slot_o     (slot),
    .nxt_slot_o (nxt_slot)
  );

  sdp_tx #(.WORD_W(WORD_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .fall_i     (fall),
    .nxt_slot_i (nxt_slot),
    .mono_i     (cfg_q.mono),
    .tx_valid_i (tx_valid_i),
    .tx_left_i  (tx_left_i),
    .tx_right_i (tx_right_i),
    .tx_ready_o (tx_ready_o),
    .sdout_o    (sdout_o)
  );

  sdp_rx #(.WORD_W(WORD_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .rise_i     (rise),
    .fall_i     (fall),
    .slot_i     (slot),
    .nxt_slot_i (nxt_slot),
    .mono_i     (cfg_q.mono),
    .sdin_i     (sdin_i),
    .rx_valid_o (rx_valid_o),
    .rx_left_o  (rx_left_o),
    .rx_right_o (rx_right_o)
  );
endmodule

// File: rtl/sdp_serial_port_chk.sv
module sdp_serial_port_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              tx_valid_i,
  input logic              tx_ready_o,
  input logic              rx_valid_o,
  input logic [WORD_W-1:0] rx_left_o,
  input logic [WORD_W-1:0] rx_right_o,
  input logic              sclk_o,
  input logic              fsync_o,
  input logic              sdout_o,
  input logic              pins_oe_o,
  input logic              mce_q,
  input logic              mono_q,
  input logic [1:0]        fmt_q
);
  AST_CFG_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !mce_q) |=> ($stable(pins_oe_o) && $stable(fmt_q)));  // R2
  AST_QUIET_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pins_oe_o |=> (!sclk_o && !fsync_o && !sdout_o));  // R3
  AST_RSV_NO_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins_oe_o && fmt_q != 2'd0) |=> !sclk_o);  // R4
  AST_FSYNC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sclk_o) && $past(fsync_o)) |-> !fsync_o);  // R6
  AST_EDGE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> ($stable(sdout_o) && $stable(fsync_o)));  // R7
  AST_READY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);  // R8
  AST_RX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);  // R10
  AST_MONO_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && $past(mono_q)) |-> (rx_right_o == rx_left_o));  // R11
endmodule

bind sdp_serial_port sdp_serial_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .tx_valid_i (tx_valid_i),
  .tx_ready_o (tx_ready_o),
  .rx_valid_o (rx_valid_o),
  .rx_left_o  (rx_left_o),
  .rx_right_o (rx_right_o),
  .sclk_o     (sclk_o),
  .fsync_o    (fsync_o),
  .sdout_o    (sdout_o),
  .pins_oe_o  (pins_oe_o),
  .mce_q      (cfg_q.mce),
  .mono_q     (cfg_q.mono),
  .fmt_q      (cfg_q.fmt)
);

// File: tb/sdp_serial_port_bench.sv
module sdp_serial_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int FRAME_CYC  = 64 * DIV;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 0, cfg_mce = 0, cfg_en = 0, cfg_mono = 0;
  logic [1:0]  cfg_fmt = 0;
  logic        tx_valid = 0, tx_ready;
  logic [15:0] tx_left = 0, tx_right = 0;
  logic        rx_valid;
  logic [15:0] rx_left, rx_right;
  logic        sdin = 0, sclk, fsync, sdout, pins_oe;

  sdp_serial_port #(.CLK_DIV(DIV), .WORD_W(16)) u_sdp_serial_port (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_mce_i(cfg_mce), .cfg_en_i(cfg_en),
    .cfg_fmt_i(cfg_fmt), .cfg_mono_i(cfg_mono),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .tx_left_i(tx_left), .tx_right_i(tx_right),
    .rx_valid_o(rx_valid), .rx_left_o(rx_left), .rx_right_o(rx_right),
    .sdin_i(sdin), .sclk_o(sclk), .fsync_o(fsync), .sdout_o(sdout),
    .pins_oe_o(pins_oe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int cyc = 0, last_rise = 0, rise_count = 0, dslot = 0;
  int rises_total = 0, timing_err = 0, spurious = 0;
  int feed_k = 0, rx_j = 0;
  bit prev_sclk = 0, prev_fsync = 0, have_rise = 0, seen_sync = 0;
  bit drv_on = 0, rx_full = 0, tail_nz = 0, model_full = 0, acc_pending = 0;
  bit feed_on = 0, bench_mono = 0;
  logic [31:0] cur_exp = 0, pend_exp = 0, cap = 0, model_hold = 0, acc_val = 0, rx_cur = 0;
  string tag_tx = "R7", tag_rx = "R9";

  function automatic logic [31:0] tx_pat(input int k);
    logic [15:0] l;
    l = 16'(k * 4951 + 32769);
    return {l, ~l ^ 16'(k * 8)};
  endfunction

  function automatic logic [31:0] rx_pat(input int j);
    return {16'(j * 9320) ^ 16'h7fff, 16'(j * 3855 + 32768)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reset_track();
    seen_sync = 0; have_rise = 0; drv_on = 0; rx_full = 0; sdin = 0;
  endtask

  // one cycle: wait for the quiet half, then model and check what the last edge did
  task automatic step();
    @(negedge clk);
    cyc++;
    if (fsync && !prev_fsync) begin
      pend_exp = model_full ? (bench_mono ? {model_hold[31:16], 16'h0} : model_hold) : 32'h0;
      model_full = 0;
      if (rx_full)
        check(rx_valid && {rx_left, rx_right} ==
              {rx_cur[31:16], bench_mono ? rx_cur[31:16] : rx_cur[15:0]},
              tag_rx, {31'b0, rx_valid, rx_left, rx_right},
              {32'h1, rx_cur[31:16], bench_mono ? rx_cur[31:16] : rx_cur[15:0]});
      else
        check(!rx_valid, "R10 no pulse before a full frame", 64'(rx_valid), 64'h0);
      rx_full = 0; rx_cur = rx_pat(rx_j); rx_j++;
      dslot = -1; drv_on = 1; sdin = 0;
    end else begin
      if (rx_valid) spurious++;
      if (!sclk && prev_sclk && drv_on && !fsync) begin
        dslot++;
        sdin = (dslot < 32) ? rx_cur[31 - dslot] : 1'b1;  // R9 tail slots carry junk
        if (dslot == 31) rx_full = 1;
      end
    end
    if (acc_pending) begin
      model_hold = acc_val; model_full = 1; acc_pending = 0; feed_k++;
    end
    {tx_left, tx_right} = tx_pat(feed_k);
    tx_valid = feed_on;
    if (tx_valid && tx_ready) begin
      acc_pending = 1; acc_val = {tx_left, tx_right};
    end
    if (!sclk && prev_sclk && have_rise && (cyc - last_rise) != DIV / 2) timing_err++;
    if (sclk && !prev_sclk) begin
      rises_total++;
      if (have_rise && (cyc - last_rise) != DIV) timing_err++;
      last_rise = cyc; have_rise = 1;
      if (fsync) begin
        if (seen_sync) begin
          check(rise_count == 63, "R6 bit periods between syncs", 64'(rise_count + 1), 64'd64);
          check(cap == cur_exp && !tail_nz, tag_tx, {31'b0, tail_nz, cap}, {32'b0, cur_exp});
        end
        seen_sync = 1; cur_exp = pend_exp; rise_count = 0; cap = 0; tail_nz = 0;
      end else if (seen_sync) begin
        if (rise_count < 32) cap[31 - rise_count] = sdout;
        else if (sdout) tail_nz = 1;
        rise_count++;
      end
    end
    prev_sclk = sclk; prev_fsync = fsync;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic cfg_write(input bit mce, input bit en, input logic [1:0] fmt, input bit mono);
    cfg_we = 1; cfg_mce = mce; cfg_en = en; cfg_fmt = fmt; cfg_mono = mono;
    step();
    cfg_we = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R5 watchdog expired: actual=hung expected=done");
    finish_run();
  end

  int r0;
  initial begin
    run(3);
    rst_n = 1;
    run(3);
    // R1 reset state
    check(!pins_oe && !sclk && !fsync && !sdout && !rx_valid && tx_ready,
          "R1 reset outputs", {58'b0, pins_oe, sclk, fsync, sdout, rx_valid, tx_ready}, 64'h1);

    // R2 enable ignored while the gate is closed
    cfg_write(0, 1, 0, 0);
    run(40);
    check(!pins_oe && rises_total == 0, "R2 enable write with gate closed",
          {31'b0, pins_oe, 32'(rises_total)}, 64'h0);

    // R3 open the gate, start the port
    cfg_write(1, 0, 0, 0);
    cfg_write(1, 1, 0, 0);
    check(pins_oe, "R3 output enable follows enable", 64'(pins_oe), 64'h1);
    feed_on = 1; tag_tx = "R7"; tag_rx = "R9";
    run(8 * FRAME_CYC + 20);

    // R4 reserved format
    cfg_write(1, 1, 2'd1, 0);
    reset_track();
    r0 = rises_total;
    run(300);
    check(rises_total == r0 && pins_oe && !fsync && !sdout, "R4 reserved format idle",
          {31'b0, pins_oe, 32'(rises_total - r0)}, {31'b0, 1'b1, 32'h0});

    // R2 format write ignored with gate closed
    cfg_write(0, 1, 2'd1, 0);
    cfg_write(0, 1, 2'd0, 0);
    r0 = rises_total;
    run(300);
    check(rises_total == r0, "R2 format write with gate closed", 64'(rises_total - r0), 64'h0);

    // back to format 0, then an underrun stretch
    cfg_write(1, 1, 2'd1, 0);
    cfg_write(1, 1, 2'd0, 0);
    run(6 * FRAME_CYC);
    feed_on = 0; tag_tx = "R8 underrun";
    run(4 * FRAME_CYC);
    feed_on = 1; tag_tx = "R8 refill";
    run(3 * FRAME_CYC);

    // R3 disable; mono set while stopped
    cfg_write(1, 0, 0, 1);
    bench_mono = 1;
    reset_track();
    run(10);
    check(!pins_oe && !sclk && !fsync && !sdout, "R3 disabled pins quiet",
          {60'b0, pins_oe, sclk, fsync, sdout}, 64'h0);

    // R11 mono frames
    tag_tx = "R11 mono tx"; tag_rx = "R11 mono rx";
    cfg_write(1, 1, 0, 1);
    run(6 * FRAME_CYC);

    // R2 disable ignored with gate closed
    cfg_write(0, 1, 0, 1);
    cfg_write(0, 0, 0, 1);
    r0 = rises_total;
    run(3 * FRAME_CYC);
    check(pins_oe && (rises_total - r0) >= 64, "R2 disable write with gate closed",
          {31'b0, pins_oe, 32'(rises_total - r0)}, {31'b0, 1'b1, 32'd64});

    check(timing_err == 0, "R5 bit clock timing errors", 64'(timing_err), 64'h0);
    check(spurious == 0, "R10 stray valid pulses", 64'(spurious), 64'h0);
    finish_run();
  end
endmodule